// File: doc/BRIEF.md
# Deferred Effective Address Resolver

This block turns the short address field of a memory-reference instruction into the final word address for a 16-bit, word-addressed processor. A direct reference takes the 11-bit field and ORs in the block bits of the program counter (bits 14..11). An indirect reference treats that location as a pointer cell. The block reads the cell through a synchronous RAM port, one read per level. Bit 15 of each pointer word decides whether another level of indirection follows.

A small window of cells acts as auto-increment pointers. These are the cells whose low 11 address bits lie between 8 and 15. When the chain passes through one of them, the block increments the stored word, writes it back, and uses the new value as the pointer. A configurable depth limit ends a runaway pointer loop with an error pulse instead of a hang. The instruction sequencer pulses `start` and waits for `done` or `error`. The RAM port is shared with the rest of the core while this block is idle.

Top module: `ea_resolver`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `error`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: For a direct request (start with `indirect`=0), `done` pulses in the cycle after the start edge. `eff_addr` then equals `(pc & 0x7800) | addr_field`, masked to the memory size. No RAM access takes place.
- R3: For an indirect request, the first pointer cell is the direct address from R2. Each level costs two cycles: a read cycle, then a cycle in which the returned word is used. A chain of n levels raises `done` 2n+1 cycles after the start edge, and `busy` is 1 in every cycle in between.
- R4: After each pointer word is obtained, bit 15 of that word (after any increment) selects the next step. If it is 1, the word is used as the address of another pointer cell. If it is 0, the word is the final effective address.
- R5: A pointer cell whose address has low 11 bits in the range 8..15 is auto-increment. Its word is incremented modulo 2^16 and written back to the same cell in the cycle after its read, and the incremented word is used in R4. No other cell is ever written.
- R6: Every address, whether used for a RAM access or driven on `eff_addr`, is the value ANDed with MEM_WORDS-1.
- R7: If bit 15 is still 1 after MAX_DEPTH pointer reads, `error` pulses in place of `done`, 2·MAX_DEPTH+1 cycles after the start edge, and the block returns to idle.
- R8: `start` is ignored while `busy` is 1. A second start during a chain changes neither the result nor its timing.
- R9: `done` and `error` are single-cycle pulses and never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a resolution (accepted only when idle) |
| addr_field | input | 11 | Address field of the instruction |
| indirect | input | 1 | Indirect flag of the instruction |
| pc | input | 16 | Current program counter, source of the block bits |
| busy | output | 1 | A pointer chain is being followed |
| done | output | 1 | One-cycle pulse: `eff_addr` is valid |
| error | output | 1 | One-cycle pulse: depth limit exceeded |
| eff_addr | output | $clog2(MEM_WORDS) | Resolved effective address |
| mem_addr | output | $clog2(MEM_WORDS) | RAM address for reads and write-back |
| mem_rd_en | output | 1 | RAM read strobe; data returns on the next cycle |
| mem_wr_en | output | 1 | RAM write strobe for auto-increment write-back |
| mem_wdata | output | 16 | Incremented pointer word to write back |
| mem_rdata | input | 16 | RAM read data, valid one cycle after `mem_rd_en` |

## Verification
The hardest states to reach are those where an auto-increment cell sits in the middle of a deferred chain, or where the increment itself changes bit 15. In those cases the write-back both moves the pointer and decides whether the chain goes on. The stimulus reaches them with prepared RAM contents: a chain that enters cell 014 at its second level, an increment of 0xFFFF that wraps to a final address of 0, and a cell at a higher block whose low bits fall in the window. A self-referencing pointer drives the depth limit to its end. A second start, injected in the read cycle, shows that a busy request is not disturbed.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int WORD_W    = 16;
    localparam int FIELD_W   = 11;
    localparam int DEFER_BIT = 15;
    localparam logic [WORD_W-1:0] BLOCK_MASK = 16'h7800;
    localparam int AI_FIRST  = 8;
    localparam int AI_LAST   = 15;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_USE  = 2'd2
    } chain_state_e;

    // result of consuming one fetched pointer word
    typedef struct packed {
        logic  wb;      // write the word back (auto-increment cell)
        logic  defer;   // another level follows
        word_t word;    // pointer word after optional increment
    } step_t;

    function automatic logic in_autoinc_window(word_t a);
        logic [FIELD_W-1:0] low;
        low = a[FIELD_W-1:0];
        return (low >= FIELD_W'(AI_FIRST)) && (low <= FIELD_W'(AI_LAST));
    endfunction

    function automatic word_t direct_address(word_t pc, logic [FIELD_W-1:0] field);
        return (pc & BLOCK_MASK) | word_t'(field);
    endfunction

endpackage

// File: rtl/ea_step_unit.sv
module ea_step_unit
    import ea_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic [AW-1:0] cell_addr,
    input  word_t         cell_word,
    output step_t         step
);
    logic  autoinc;
    word_t next_word;

    always_comb begin
        autoinc   = in_autoinc_window(word_t'(cell_addr));
        next_word = autoinc ? cell_word + word_t'(1) : cell_word;
        step.wb    = autoinc;
        step.word  = next_word;
        step.defer = next_word[DEFER_BIT];
    end

endmodule

// File: rtl/ea_chain_ctl.sv
module ea_chain_ctl
    import ea_pkg::*;
#(
    parameter int AW        = 11,
    parameter int MAX_DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          indirect,
    input  logic [AW-1:0] base_addr,
    input  step_t         step,
    output logic [AW-1:0] cell_addr,
    output logic          rd_en,
    output logic          wr_en,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] eff_addr
);
    localparam int DW = $clog2(MAX_DEPTH + 1);

    chain_state_e  st_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] eff_q;
    logic [DW-1:0] depth_q;
    logic          done_q;
    logic          err_q;
    logic [AW-1:0] next_ptr;

    assign next_ptr = AW'(step.word);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ptr_q   <= '0;
            eff_q   <= '0;
            depth_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        if (indirect) begin
                            ptr_q   <= base_addr;
                            depth_q <= '0;
                            st_q    <= ST_READ;
                        end else begin
                            eff_q  <= base_addr;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    depth_q <= depth_q + DW'(1);
                    st_q    <= ST_USE;
                end
                ST_USE: begin
                    if (step.defer) begin
                        if (depth_q == DW'(MAX_DEPTH)) begin
                            err_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end else begin
                            ptr_q <= next_ptr;
                            st_q  <= ST_READ;
                        end
                    end else begin
                        eff_q  <= next_ptr;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cell_addr = ptr_q;
    assign rd_en     = (st_q == ST_READ);
    assign wr_en     = (st_q == ST_USE) && step.wb;
    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign error     = err_q;
    assign eff_addr  = eff_q;

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        depth_q <= DW'(MAX_DEPTH)) else $error("depth counter beyond limit"); // R7
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_q && err_q)) else $error("done and error together"); // R9
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_READ) |=> (st_q == ST_USE) && $stable(ptr_q)) else $error("chain disturbed"); // R8
    AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && start && !indirect) |=> done_q && (eff_q == $past(base_addr)))
        else $error("direct request not completed"); // R2

endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
    import ea_pkg::*;
#(
    parameter int MEM_WORDS = 2048,
    parameter int MAX_DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [FIELD_W-1:0]           addr_field,
    input  logic                         indirect,
    input  logic [WORD_W-1:0]            pc,
    output logic                         busy,
    output logic                         done,
    output logic                         error,
    output logic [$clog2(MEM_WORDS)-1:0] eff_addr,
    output logic [$clog2(MEM_WORDS)-1:0] mem_addr,
    output logic                         mem_rd_en,
    output logic                         mem_wr_en,
    output logic [WORD_W-1:0]            mem_wdata,
    input  logic [WORD_W-1:0]            mem_rdata
);
    localparam int AW = $clog2(MEM_WORDS);

    logic [AW-1:0] base_addr;
    logic [AW-1:0] cell_addr;
    step_t         step;

    assign base_addr = AW'(direct_address(pc, addr_field));

    ea_step_unit #(.AW(AW)) step_i (
        .cell_addr (cell_addr),
        .cell_word (mem_rdata),
        .step      (step)
    );

    ea_chain_ctl #(.AW(AW), .MAX_DEPTH(MAX_DEPTH)) ctl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .indirect  (indirect),
        .base_addr (base_addr),
        .step      (step),
        .cell_addr (cell_addr),
        .rd_en     (mem_rd_en),
        .wr_en     (mem_wr_en),
        .busy      (busy),
        .done      (done),
        .error     (error),
        .eff_addr  (eff_addr)
    );

    assign mem_addr  = cell_addr;
    assign mem_wdata = step.word;

    AST_WB_SAME_CELL: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> $past(mem_rd_en) && (mem_addr == $past(mem_addr)))
        else $error("write-back not to the cell just read"); // R5
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en)) else $error("read and write together"); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd_en && !mem_wr_en) else $error("RAM access while idle"); // R2

endmodule

// File: tb/ea_resolver_tb_top.sv
module ea_resolver_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 8192;
    localparam int MD = 4;
    localparam int AW = $clog2(MW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [10:0]   addr_field = '0;
    logic          indirect = 1'b0;
    logic [15:0]   pc = '0;
    logic          busy, done, error;
    logic [AW-1:0] eff_addr, mem_addr;
    logic          mem_rd_en, mem_wr_en;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;

    logic [15:0] ram   [MW];
    logic [15:0] model [MW];

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_resolver #(.MEM_WORDS(MW), .MAX_DEPTH(MD)) dut_i (
        .clk(clk), .rst(rst), .start(start), .addr_field(addr_field),
        .indirect(indirect), .pc(pc), .busy(busy), .done(done), .error(error),
        .eff_addr(eff_addr), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_wr_en) ram[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= ram[mem_addr];
    end

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                failures++;
                $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
                summary_and_end();
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic setm(input int a, input logic [15:0] v);
        ram[a]   = v;
        model[a] = v;
    endtask

    // reference: window is low 11 address bits within 8..15
    function automatic bit ref_autoinc(input int a);
        int low;
        low = a % 2048;
        return (low >= 8) && (low <= 15);
    endfunction

    task automatic run_op(input string req, input logic [10:0] f, input bit ind,
                          input logic [15:0] p, input bit poke);
        int a;
        int levels;
        int lat;
        bit exp_err;
        int exp_eff;
        logic [15:0] w;
        a = ((int'(p) & 'h7800) | int'(f)) & (MW - 1);
        levels = 0;
        exp_err = 0;
        exp_eff = a;
        if (ind) begin
            while (1) begin
                levels++;
                w = model[a];
                if (ref_autoinc(a)) begin
                    w = w + 16'd1;
                    model[a] = w;
                end
                a = int'(w) & (MW - 1);
                if (!w[15]) begin
                    exp_eff = a;
                    break;
                end
                if (levels == MD) begin
                    exp_err = 1;
                    break;
                end
            end
        end
        lat = 2 * levels + 1;
        addr_field = f;
        indirect = ind;
        pc = p;
        start = 1'b1;
        for (int c = 1; c <= lat; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (c < lat) begin
                chk(busy == 1'b1, req, "busy during chain", busy, 1);
                chk(done == 1'b0 && error == 1'b0, req, "early completion", {done, error}, 0);
            end else begin
                chk(busy == 1'b0, req, "busy at end", busy, 0);
                chk(done == !exp_err, req, "done pulse", done, !exp_err);
                chk(error == exp_err, req, "error pulse", error, exp_err);
                if (!exp_err) chk(int'(eff_addr) == exp_eff, req, "eff_addr", eff_addr, exp_eff);
            end
            if (poke && c == 1) begin
                start = 1'b1;
                indirect = 1'b0;
                addr_field = ~f;
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && error == 1'b0, "R9", "pulse width", {done, error}, 0);
        begin
            int bad;
            int bad_at;
            bad = 0;
            bad_at = 0;
            for (int i = 0; i < MW; i++) begin
                if (ram[i] !== model[i]) begin
                    if (bad == 0) bad_at = i;
                    bad++;
                end
            end
            chk(bad == 0, "R5", "RAM contents vs model", bad_at, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < MW; i++) begin
            ram[i] = 16'(i * 7);
            model[i] = 16'(i * 7) & 16'h7FFF;
            ram[i] = model[i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && error == 0, "R1", "status in reset", {busy, done, error}, 0);
        chk(mem_rd_en == 0 && mem_wr_en == 0, "R1", "RAM strobes in reset", {mem_rd_en, mem_wr_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0, "R1", "status after reset", {busy, done, error}, 0);

        // R2 direct, with and without block bits (R6 masks bit 14..13)
        run_op("R2", 11'o0123, 1'b0, 16'h0000, 1'b0);
        run_op("R2", 11'o0005, 1'b0, 16'h7FFF, 1'b0);
        run_op("R6", 11'o1777, 1'b0, 16'h1800, 1'b0);

        // R3 single level
        setm('o101, 16'o0200);
        run_op("R3", 11'o0101, 1'b1, 16'h0000, 1'b0);

        // R4 two-level chain
        setm('o101, 16'o100200);
        setm('o200, 16'o0300);
        run_op("R4", 11'o0101, 1'b1, 16'h0000, 1'b0);

        // R5 auto-increment: 010 holding 0200 -> 0201
        setm('o010, 16'o0200);
        run_op("R5", 11'o0010, 1'b1, 16'h0000, 1'b0);
        chk(ram['o010] == 16'o0201, "R5", "cell 010 after write-back", ram['o010], 'o201);
        // window edges
        setm('o017, 16'o0400);
        run_op("R5", 11'o0017, 1'b1, 16'h0000, 1'b0);
        setm('o020, 16'o0500);
        run_op("R5", 11'o0020, 1'b1, 16'h0000, 1'b0);
        setm('o007, 16'o0600);
        run_op("R5", 11'o0007, 1'b1, 16'h0000, 1'b0);
        // window cell in a higher block
        setm('h0808, 16'h0123);
        run_op("R5", 11'o0010, 1'b1, 16'h0800, 1'b0);
        // increment wraps to zero
        setm('o011, 16'hFFFF);
        run_op("R5", 11'o0011, 1'b1, 16'h0000, 1'b0);
        // window cell mid-chain, increment keeps defer bit
        setm('o103, 16'h8000 | 16'o014);
        setm('o014, 16'h8700);
        setm('h0701, 16'h0042);
        run_op("R4", 11'o0103, 1'b1, 16'h0000, 1'b0);

        // R6 pointer masked to memory size
        setm('o102, 16'h7FFF);
        run_op("R6", 11'o0102, 1'b1, 16'h0000, 1'b0);

        // R7 self loop exceeds depth
        setm('o300, 16'h8000 | 16'o0300);
        run_op("R7", 11'o0300, 1'b1, 16'h0000, 1'b0);

        // R8 second start while busy is ignored
        setm('o101, 16'o0200);
        run_op("R8", 11'o0101, 1'b1, 16'h0000, 1'b1);
        setm('o101, 16'o100200);
        run_op("R8", 11'o0101, 1'b1, 16'h0000, 1'b1);

        summary_and_end();
    end

endmodule